// File: doc/BRIEF.md
# Memory-Mapped 64-bit Machine Timer

This block is a machine-mode timer that a 32-bit core reaches through simple read and write strobes. It keeps a free-running 64-bit time count and a 64-bit compare value. Each is visible as a pair of 32-bit words. While the count is at or beyond the compare value, it drives a level interrupt toward the core on machine interrupt line 7. The timer is one-shot. After it fires, the interrupt stays up until software writes a compare value ahead of the current count.

Reading a 64-bit count over a 32-bit bus risks a torn value when a carry crosses into the upper half between the two reads. To avoid this, a read of the low count word also stores the count's upper half in a holding register. A read of the high count word returns that holding register and never the live count. Software therefore reads the low word first and the high word second. The count advances either on an input strobe or on every clock, as chosen by a parameter. Software can load either half of the count directly.

The interrupt is produced by a two-state machine. QUIET means the count is below the compare value, and FIRED means the count is at or above it. Two transitions leave a state: QUIET to FIRED when the count reaches the compare value (fire), and FIRED to QUIET when the compare value moves ahead of the count (rearm). The other two transitions are the self-loops QUIET to QUIET (wait) and FIRED to FIRED (hold). The output irq_o is high exactly in FIRED.

Top module: `mtimer_top`

## Requirements
- R1: After reset the count and the holding register are zero, both compare words read 0xFFFFFFFF, and irq_o is low.
- R2: With the strobe tick source selected, the count rises by one on each clock edge where tick_i is high and no count word is being written. It wraps from all-ones to zero.
- R3: The word map is as follows, with reads returned on rdata_o combinationally in the same cycle as rd_en_i. Offset 0x0 is the count's low word. Offset 0x4 is the count's high word, which reads the holding register. Offset 0x8 is the compare value's low word. Offset 0xC is the compare value's high word.
- R4: A read of offset 0x0 copies the upper 32 bits of the live count into the holding register at that clock edge. No other access changes the holding register.
- R5: A read of offset 0x4 returns the holding register. The value is unchanged by carries into the count's upper half that occur after the last low-word read.
- R6: A write to offset 0x0 or 0x4 loads that half of the count with wdata_i and leaves the other half unchanged. The count does not increment in that cycle, even when tick_i is high.
- R7: A write to offset 0x8 or 0xC loads only that half of the compare value.
- R8: irq_o is high in the cycle after any clock edge at which the count, taken as an unsigned 64-bit number, is greater than or equal to the compare value, including when only the upper words decide the result. In the cycle after an edge where the count is below the compare value, irq_o is low.
- R9: Once fired, irq_o stays high until a compare write places the compare value above the count. It then drops one cycle after the edge at which that write takes effect.
- R10: Any address other than exactly 0x0, 0x4, 0x8 or 0xC reads as zero. A write to such an address changes neither the count nor the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-advance strobe (used when the strobe tick source is selected) |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (5) | Byte offset within the timer region |
| wdata_i | input | BUS_W (32) | Write data |
| rdata_o | output | BUS_W (32) | Read data, valid in the same cycle as rd_en_i |
| irq_o | output | 1 | Machine timer interrupt, level |

## Verification
Read data is combinational, so each read is checked shortly after the inputs change in the same cycle as rd_en_i. The holding register and the count are updated at the following edge, and their effect is checked through a later read. A write or a tick changes the count or the compare value at the edge where the strobe is sampled. The interrupt state machine registers the comparison one edge later, so irq_o is sampled two falling edges after the stimulus. The comparison is swept with compare offsets from -3 to +3 around several counts, including counts that sit at a word boundary or near all-ones, and the expected level is computed in 64-bit arithmetic in the bench.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    // Byte offsets of the four mapped words
    localparam int OFF_CNT_LO = 'h0;
    localparam int OFF_CNT_HI = 'h4;
    localparam int OFF_CMP_LO = 'h8;
    localparam int OFF_CMP_HI = 'hC;

    // Machine interrupt line the output is wired to
    localparam int MTIMER_IRQ_LINE = 7;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_CMP_LO = 3'd3,
        SEL_CMP_HI = 3'd4
    } word_sel_e;

    typedef enum logic {
        IRQ_QUIET = 1'b0,
        IRQ_FIRED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
    import mtimer_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output word_sel_e         sel_o
);

    always_comb begin
        if (addr_i == ADDR_W'(OFF_CNT_LO))      sel_o = SEL_CNT_LO;
        else if (addr_i == ADDR_W'(OFF_CNT_HI)) sel_o = SEL_CNT_HI;
        else if (addr_i == ADDR_W'(OFF_CMP_LO)) sel_o = SEL_CMP_LO;
        else if (addr_i == ADDR_W'(OFF_CMP_HI)) sel_o = SEL_CMP_HI;
        else                                    sel_o = SEL_NONE;
    end

endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
    parameter int BUS_W          = 32,
    parameter int CNT_W          = 2 * BUS_W,
    parameter bit TICK_EVERY_CLK = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic             tick_en;
    logic [CNT_W-1:0] cnt_q;

    generate
        if (TICK_EVERY_CLK) begin : g_free_run
            assign tick_en = 1'b1;
        end else begin : g_strobe
            assign tick_en = tick_i;
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (ld_lo_i || ld_hi_i) begin
            if (ld_lo_i) cnt_q[BUS_W-1:0]     <= wdata_i;
            if (ld_hi_i) cnt_q[CNT_W-1:BUS_W] <= wdata_i;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R2
    cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en && !ld_lo_i && !ld_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    cnt_ld_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_lo_i |=> (cnt_q[BUS_W-1:0] == $past(wdata_i)) &&
                    (cnt_q[CNT_W-1:BUS_W] == $past(cnt_q[CNT_W-1:BUS_W])));

endmodule

// File: rtl/mtimer_snapshot.sv
module mtimer_snapshot #(
    parameter int BUS_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_i,
    input  logic [BUS_W-1:0] upper_i,
    output logic [BUS_W-1:0] hold_o
);

    logic [BUS_W-1:0] hold_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)    hold_q <= '0;
        else if (cap_i) hold_q <= upper_i;
    end

    assign hold_o = hold_q;

    // R4
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_i |=> $stable(hold_q));

endmodule

// File: rtl/mtimer_compare.sv
module mtimer_compare #(
    parameter int BUS_W = 32,
    parameter int CNT_W = 2 * BUS_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cmp_o
);

    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cmp_q <= '1;
        end else begin
            if (ld_lo_i) cmp_q[BUS_W-1:0]     <= wdata_i;
            if (ld_hi_i) cmp_q[CNT_W-1:BUS_W] <= wdata_i;
        end
    end

    assign cmp_o = cmp_q;

    // R7
    cmp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_lo_i && !ld_hi_i) |=> $stable(cmp_q));

endmodule

// File: rtl/mtimer_irq_fsm.sv
module mtimer_irq_fsm
    import mtimer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             irq_o
);

    irq_state_e st_q, st_d;
    logic       due;

    assign due = (cnt_i >= cmp_i);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_QUIET: st_d = due ? IRQ_FIRED : IRQ_QUIET;  // fire / wait
            IRQ_FIRED: st_d = due ? IRQ_FIRED : IRQ_QUIET;  // hold / rearm
            default:   st_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= IRQ_QUIET;
        else         st_q <= st_d;
    end

    always_comb begin
        irq_o = (st_q == IRQ_FIRED);
    end

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int BUS_W          = 32,
    parameter int ADDR_W         = 5,
    parameter bit TICK_EVERY_CLK = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              irq_o
);

    localparam int CNT_W = 2 * BUS_W;

    word_sel_e        sel;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp;
    logic [BUS_W-1:0] hold;

    mtimer_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    mtimer_counter #(
        .BUS_W          (BUS_W),
        .CNT_W          (CNT_W),
        .TICK_EVERY_CLK (TICK_EVERY_CLK)
    ) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .ld_lo_i (wr_en_i && sel == SEL_CNT_LO),
        .ld_hi_i (wr_en_i && sel == SEL_CNT_HI),
        .wdata_i (wdata_i),
        .cnt_o   (cnt)
    );

    mtimer_snapshot #(.BUS_W(BUS_W)) u_snapshot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cap_i   (rd_en_i && sel == SEL_CNT_LO),
        .upper_i (cnt[CNT_W-1:BUS_W]),
        .hold_o  (hold)
    );

    mtimer_compare #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_compare (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ld_lo_i (wr_en_i && sel == SEL_CMP_LO),
        .ld_hi_i (wr_en_i && sel == SEL_CMP_HI),
        .wdata_i (wdata_i),
        .cmp_o   (cmp)
    );

    mtimer_irq_fsm #(.CNT_W(CNT_W)) u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_i  (cnt),
        .cmp_i  (cmp),
        .irq_o  (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (sel)
                SEL_CNT_LO: rdata_o = cnt[BUS_W-1:0];
                SEL_CNT_HI: rdata_o = hold;
                SEL_CMP_LO: rdata_o = cmp[BUS_W-1:0];
                SEL_CMP_HI: rdata_o = cmp[CNT_W-1:BUS_W];
                default:    rdata_o = '0;
            endcase
        end
    end

    // R8
    irq_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt >= cmp) |=> irq_o);

    // R9
    irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt < cmp) |=> !irq_o);

    // R10
    unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && sel == SEL_NONE) |-> (rdata_o == '0));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && sel == SEL_NONE && !tick_i) |=> $stable(cnt) && $stable(cmp));

endmodule

// File: tb/mtimer_top_tb.sv
module mtimer_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mtimer_top #(.BUS_W(32), .ADDR_W(5), .TICK_EVERY_CLK(1'b0)) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .tick_i  (tick),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        check(rdata, exp, tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        @(negedge clk);
        check({31'd0, irq}, {31'd0, exp}, tag);
    endtask

    task automatic set64(input logic [4:0] base, input logic [63:0] v);
        wr(base, v[31:0]);
        wr(base + 5'd4, v[63:32]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check({31'd0, irq}, 32'd0, "R1 irq");
        rd(5'h0, 32'h0, "R1 cnt lo");
        rd(5'h4, 32'h0, "R1 cnt hi");
        rd(5'h8, 32'hFFFF_FFFF, "R1 cmp lo");
        rd(5'hC, 32'hFFFF_FFFF, "R1 cmp hi");

        // R2 counting on strobe
        pulse(10);
        rd(5'h0, 32'd10, "R2 count ten");
        rd(5'h4, 32'd0, "R2 upper zero");

        // R6 direct loads, R4 hold untouched by writes
        set64(5'h0, 64'h0000_0005_FFFF_FFFE);
        rd(5'h4, 32'd0, "R4 hold before low read");
        rd(5'h0, 32'hFFFF_FFFE, "R6 low loaded");
        // R5 carry between low and high reads
        pulse(4);
        rd(5'h4, 32'd5, "R5 hold ignores carry");
        rd(5'h0, 32'd2, "R3 low after carry");
        rd(5'h4, 32'd6, "R4 new snapshot");

        // R6 write wins over tick in same cycle
        @(negedge clk);
        tick = 1'b1; addr = 5'h0; wdata = 32'h50; wr_en = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(5'h0, 32'h50, "R6 write beats tick");
        rd(5'h0, 32'h50, "R6 low stable");
        rd(5'h4, 32'd6, "R6 high half kept");

        // R2 wrap
        set64(5'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        pulse(1);
        rd(5'h0, 32'd0, "R2 wrap low");
        rd(5'h4, 32'd0, "R2 wrap high");

        // R7 compare halves
        wr(5'h8, 32'h1234_5678);
        rd(5'h8, 32'h1234_5678, "R7 cmp lo");
        rd(5'hC, 32'hFFFF_FFFF, "R7 cmp hi kept");

        // R10 unmapped
        wr(5'h10, 32'hDEAD_BEEF);
        wr(5'h01, 32'hDEAD_BEEF);
        rd(5'h10, 32'd0, "R10 read 0x10");
        rd(5'h1C, 32'd0, "R10 read 0x1C");
        rd(5'h02, 32'd0, "R10 read 0x02");
        rd(5'h8, 32'h1234_5678, "R10 cmp lo intact");
        rd(5'hC, 32'hFFFF_FFFF, "R10 cmp hi intact");
        rd(5'h0, 32'd0, "R10 cnt lo intact");
        rd(5'h4, 32'd0, "R10 cnt hi intact");

        // R8 sweep of compare offsets around several counts
        for (int b = 0; b < 3; b++) begin
            logic [63:0] base;
            base = (b == 0) ? 64'h10 : (b == 1) ? 64'h0000_0001_0000_0001
                                                : 64'hFFFF_FFFF_FFFF_FFF0;
            for (int d = -3; d <= 3; d++) begin
                logic [63:0] cv;
                cv = base + 64'(signed'(d));
                set64(5'h0, base);
                set64(5'h8, cv);
                chk_irq(base >= cv, $sformatf("R8 sweep base %0d delta %0d", b, d));
            end
        end

        // R8 upper words decide
        set64(5'h0, 64'h0000_0001_0000_0000);
        set64(5'h8, 64'h0000_0000_FFFF_FFFF);
        chk_irq(1'b1, "R8 upper word decides");
        // R9 compare high rewrite moves ahead
        wr(5'hC, 32'd1);
        chk_irq(1'b0, "R9 clear by high write");

        // R8/R9 arm, approach, fire, rearm
        set64(5'h0, 64'd100);
        set64(5'h8, 64'd103);
        chk_irq(1'b0, "R8 below compare");
        pulse(2);
        chk_irq(1'b0, "R8 one short");
        pulse(1);
        chk_irq(1'b1, "R8 fires at compare");
        pulse(3);
        chk_irq(1'b1, "R9 stays high past compare");
        wr(5'h8, 32'd200);
        chk_irq(1'b0, "R9 rearm clears");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule